// File: doc/BRIEF.md
# Receive Transfer Sequencer for the PHY-to-Link Bus

This block sits between the receive side of a serial-bus physical layer and the link layer. The port logic reports four kinds of receive event: the start of a data prefix, the speed of the incoming packet, one data byte at a time, and the end of data. The sequencer turns them into a fixed pattern on a 2-bit control bus and a data bus. Both buses are registered and change only on the system clock. The pattern is one or more data-on indications, then one byte holding the speed code, then the packet bytes, then a return to Idle. A packet that ends before its speed is known is a null packet. For a null packet the link sees data-on followed by Idle, and nothing else.

The node's own self-ID packet reaches the link through the same path. It is offered on a second byte stream with valid/ready handshaking. A self-ID transfer is always labelled with the slowest speed code. The self-ID source can be back-pressured: `sid_ready` is high only while the sequencer is in its self-ID data phase, and a held `sid_valid` waits until then. The port logic cannot be stalled. Its bytes are taken only while `rx_byte_ready` is high, and a byte offered at any other time is dropped. The control-bus code values and the data-on pattern are parameters. The speed code sits in the top eight bits of the data bus, so a link using only the upper data lines still decodes it.

Top module: `phy_link_rx_seq`

## Requirements
- R1: During and straight after reset, `link_ctl` is the Idle code, `link_d` is zero, and `rx_byte_ready` and `sid_ready` are both low.
- R2: A `rx_prefix` seen while the outputs show Idle produces data-on (Receive code with `link_d` = all ones) on the next cycle. At least one data-on cycle always comes before the speed byte or the return to Idle, even when speed or end arrive in the same cycle as the prefix. A speed or end arriving together with the prefix is held and used on the cycle after.
- R3: The speed byte has Receive on `link_ctl`. `rx_spd` 0 (S100) gives 8'h00, 1 (S200) gives 8'h40, 2 (S400) gives 8'h50, and the reserved value 3 is sent as 8'h50.
- R4: If `rx_end` arrives while data-on is shown and no speed has been sent, the next cycle is Idle and no speed or data byte is sent. End wins over a speed arriving in the same cycle.
- R5: After the speed byte, a byte taken with `rx_byte_valid` and `rx_byte_ready` both high appears on `link_d` with Receive for exactly the next cycle. A cycle with no byte shows data-on.
- R6: `rx_end` with no byte gives Idle on the next cycle. `rx_end` together with a byte gives the byte and then Idle. Whenever Idle is shown, `link_d` is zero.
- R7: `rx_byte_ready` is high only in the cable data phase after the speed byte. A byte offered at any other time is not forwarded.
- R8: `rx_prefix`, `rx_spd_valid` and `rx_end` are ignored while a transfer is under way. Only a prefix seen while Idle is shown starts a transfer.
- R9: When Idle is shown and `sid_valid` is high with no `rx_prefix`, the sequencer sends data-on, then 8'h00, then each self-ID byte accepted by the handshake. Each such byte appears on the cycle after acceptance, with data-on in gap cycles, and Idle follows the byte marked `sid_last`.
- R10: If `rx_prefix` and `sid_valid` are both high while Idle is shown, the cable packet wins. The self-ID stream waits with `sid_ready` low and is served after the cable transfer has returned to Idle.
- R11: `rx_byte_ready` and `sid_ready` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_prefix | input | 1 | Pulse: data prefix detected on the bus |
| rx_spd_valid | input | 1 | Pulse: packet speed is known |
| rx_spd | input | 2 | Packet speed: 0 S100, 1 S200, 2 S400 |
| rx_byte_valid | input | 1 | Received byte offered |
| rx_byte | input | DATA_W | Received byte |
| rx_byte_ready | output | 1 | Byte taken this cycle if valid |
| rx_end | input | 1 | Pulse: data end detected |
| sid_valid | input | 1 | Own self-ID byte offered (held until taken) |
| sid_data | input | DATA_W | Own self-ID byte |
| sid_last | input | 1 | Marks the final self-ID byte |
| sid_ready | output | 1 | Self-ID byte taken this cycle if valid |
| link_ctl | output | CTL_W | Control bus to the link (Idle or Receive code) |
| link_d | output | DATA_W | Data bus to the link |

## Verification
Two things can land on one edge. First, the start of a cable packet can coincide with a pending own self-ID packet. Second, the prefix, speed and end events can arrive in the same cycle. The bench provokes the first by raising `sid_valid` in the very cycle of `rx_prefix`. It then checks that the link shows the cable packet's speed byte while `sid_ready` stays low, and that the self-ID transfer with its 8'h00 speed byte follows Idle. For the second, a prefix is given together with speed or end, and the bench checks for one data-on cycle before the speed byte, or before Idle in the null case. Random traffic then repeats both situations many times against a cycle model in the bench.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAB_ON,
    ST_CAB_DATA,
    ST_OWN_ON,
    ST_OWN_DATA,
    ST_TAIL
  } seq_st_e;

  typedef enum logic [1:0] {
    SPD_S100 = 2'd0,
    SPD_S200 = 2'd1,
    SPD_S400 = 2'd2,
    SPD_RSV  = 2'd3
  } spd_e;

  typedef enum logic [1:0] {
    OUT_IDLE,
    OUT_DATAON,
    OUT_SPEED,
    OUT_BYTE
  } out_sel_e;

  // speed code as seen in the top eight data bits
  function automatic logic [7:0] speed_code(spd_e s);
    case (s)
      SPD_S100: speed_code = 8'h00;
      SPD_S200: speed_code = 8'h40;
      default:  speed_code = 8'h50;
    endcase
  endfunction

endpackage

// File: rtl/rxseq_evt_cap.sv
module rxseq_evt_cap
  import rxseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       consume,
  input  logic       rx_spd_valid,
  input  logic [1:0] rx_spd,
  input  logic       rx_end,
  output logic       spd_avail,
  output spd_e       spd_sel,
  output logic       end_seen
);

  logic pend_sv;
  spd_e pend_spd;
  logic pend_end;

  // holds speed/end that arrive in the same cycle as the prefix
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sv  <= 1'b0;
      pend_spd <= SPD_S100;
      pend_end <= 1'b0;
    end else if (arm) begin
      pend_sv  <= rx_spd_valid;
      pend_spd <= spd_e'(rx_spd);
      pend_end <= rx_end;
    end else if (consume) begin
      pend_sv  <= 1'b0;
      pend_end <= 1'b0;
    end
  end

  assign spd_avail = pend_sv | rx_spd_valid;
  assign spd_sel   = pend_sv ? pend_spd : spd_e'(rx_spd);
  assign end_seen  = pend_end | rx_end;

endmodule

// File: rtl/rxseq_spd_enc.sv
module rxseq_spd_enc
  import rxseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  spd_e              spd,
  output logic [DATA_W-1:0] code
);

  localparam int PAD_W = DATA_W - 8;

  logic [7:0] byte_code;
  assign byte_code = speed_code(spd);

  generate
    if (PAD_W == 0) begin : g_exact
      assign code = byte_code;
    end else begin : g_wide
      assign code = {byte_code, {PAD_W{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/rxseq_fsm.sv
module rxseq_fsm
  import rxseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_prefix,
  input  logic     spd_avail,
  input  logic     end_seen,
  input  logic     rx_byte_valid,
  input  logic     rx_end,
  input  logic     sid_valid,
  input  logic     sid_last,
  output out_sel_e out_sel,
  output logic     src_own,
  output logic     spd_own,
  output logic     arm,
  output logic     consume,
  output logic     rx_rdy,
  output logic     sid_rdy
);

  seq_st_e st, st_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  always_comb begin
    st_nxt  = st;
    out_sel = OUT_IDLE;
    src_own = 1'b0;
    spd_own = 1'b0;
    arm     = 1'b0;
    consume = 1'b0;
    rx_rdy  = 1'b0;
    sid_rdy = 1'b0;
    case (st)
      ST_IDLE: begin
        if (rx_prefix) begin
          arm     = 1'b1;
          out_sel = OUT_DATAON;
          st_nxt  = ST_CAB_ON;
        end else if (sid_valid) begin
          out_sel = OUT_DATAON;
          st_nxt  = ST_OWN_ON;
        end
      end
      ST_CAB_ON: begin
        if (end_seen) begin
          consume = 1'b1;
          st_nxt  = ST_IDLE;
        end else if (spd_avail) begin
          consume = 1'b1;
          out_sel = OUT_SPEED;
          st_nxt  = ST_CAB_DATA;
        end else begin
          out_sel = OUT_DATAON;
        end
      end
      ST_CAB_DATA: begin
        rx_rdy = 1'b1;
        if (rx_byte_valid) begin
          out_sel = OUT_BYTE;
          if (rx_end) st_nxt = ST_TAIL;
        end else if (rx_end) begin
          st_nxt = ST_IDLE;
        end else begin
          out_sel = OUT_DATAON;
        end
      end
      ST_OWN_ON: begin
        spd_own = 1'b1;
        out_sel = OUT_SPEED;
        st_nxt  = ST_OWN_DATA;
      end
      ST_OWN_DATA: begin
        sid_rdy = 1'b1;
        src_own = 1'b1;
        if (sid_valid) begin
          out_sel = OUT_BYTE;
          if (sid_last) st_nxt = ST_TAIL;
        end else begin
          out_sel = OUT_DATAON;
        end
      end
      default: begin
        st_nxt = ST_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/rxseq_out_reg.sv
module rxseq_out_reg
  import rxseq_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              CTL_W      = 2,
  parameter logic [CTL_W-1:0] CTL_IDLE  = 2'b00,
  parameter logic [CTL_W-1:0] CTL_RECV  = 2'b10,
  parameter logic [DATA_W-1:0] DATAON_PAT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  out_sel_e          out_sel,
  input  logic              src_own,
  input  logic [DATA_W-1:0] spd_code,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] sid_data,
  output logic [CTL_W-1:0]  link_ctl,
  output logic [DATA_W-1:0] link_d
);

  logic [DATA_W-1:0] d_nxt;
  logic [DATA_W-1:0] pay;

  assign pay = src_own ? sid_data : rx_byte;

  always_comb begin
    case (out_sel)
      OUT_DATAON: d_nxt = DATAON_PAT;
      OUT_SPEED:  d_nxt = spd_code;
      OUT_BYTE:   d_nxt = pay;
      default:    d_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_ctl <= CTL_IDLE;
      link_d   <= '0;
    end else begin
      link_ctl <= (out_sel == OUT_IDLE) ? CTL_IDLE : CTL_RECV;
      link_d   <= d_nxt;
    end
  end

endmodule

// File: rtl/phy_link_rx_seq.sv
module phy_link_rx_seq
  import rxseq_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter int               CTL_W      = 2,
  parameter logic [CTL_W-1:0] CTL_IDLE   = 2'b00,
  parameter logic [CTL_W-1:0] CTL_RECV   = 2'b10,
  parameter logic [DATA_W-1:0] DATAON_PAT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_prefix,
  input  logic              rx_spd_valid,
  input  logic [1:0]        rx_spd,
  input  logic              rx_byte_valid,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              rx_byte_ready,
  input  logic              rx_end,
  input  logic              sid_valid,
  input  logic [DATA_W-1:0] sid_data,
  input  logic              sid_last,
  output logic              sid_ready,
  output logic [CTL_W-1:0]  link_ctl,
  output logic [DATA_W-1:0] link_d
);

  out_sel_e          out_sel;
  logic              src_own, spd_own, arm, consume;
  logic              spd_avail, end_seen;
  spd_e              cab_spd, tx_spd;
  logic [DATA_W-1:0] spd_code;

  rxseq_evt_cap u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (arm),
    .consume      (consume),
    .rx_spd_valid (rx_spd_valid),
    .rx_spd       (rx_spd),
    .rx_end       (rx_end),
    .spd_avail    (spd_avail),
    .spd_sel      (cab_spd),
    .end_seen     (end_seen)
  );

  rxseq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_prefix     (rx_prefix),
    .spd_avail     (spd_avail),
    .end_seen      (end_seen),
    .rx_byte_valid (rx_byte_valid),
    .rx_end        (rx_end),
    .sid_valid     (sid_valid),
    .sid_last      (sid_last),
    .out_sel       (out_sel),
    .src_own       (src_own),
    .spd_own       (spd_own),
    .arm           (arm),
    .consume       (consume),
    .rx_rdy        (rx_byte_ready),
    .sid_rdy       (sid_ready)
  );

  // own self-ID always goes out at the slowest speed
  assign tx_spd = spd_own ? SPD_S100 : cab_spd;

  rxseq_spd_enc #(.DATA_W(DATA_W)) u_enc (
    .spd  (tx_spd),
    .code (spd_code)
  );

  rxseq_out_reg #(
    .DATA_W     (DATA_W),
    .CTL_W      (CTL_W),
    .CTL_IDLE   (CTL_IDLE),
    .CTL_RECV   (CTL_RECV),
    .DATAON_PAT (DATAON_PAT)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_sel  (out_sel),
    .src_own  (src_own),
    .spd_code (spd_code),
    .rx_byte  (rx_byte),
    .sid_data (sid_data),
    .link_ctl (link_ctl),
    .link_d   (link_d)
  );

endmodule

// File: rtl/rxseq_chk.sv
module rxseq_chk #(
  parameter int               DATA_W     = 8,
  parameter int               CTL_W      = 2,
  parameter logic [CTL_W-1:0] CTL_IDLE   = 2'b00,
  parameter logic [CTL_W-1:0] CTL_RECV   = 2'b10,
  parameter logic [DATA_W-1:0] DATAON_PAT = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_prefix,
  input logic              rx_byte_valid,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_byte_ready,
  input logic              sid_valid,
  input logic [DATA_W-1:0] sid_data,
  input logic              sid_ready,
  input logic [CTL_W-1:0]  link_ctl,
  input logic [DATA_W-1:0] link_d
);

  // R6
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ctl == CTL_IDLE) |-> (link_d == '0));

  // R2
  dataon_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ctl == CTL_IDLE && rx_prefix) |=> (link_ctl == CTL_RECV && link_d == DATAON_PAT));

  // R11
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_byte_ready && sid_ready));

  // R5
  cab_byte_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_valid && rx_byte_ready) |=> (link_ctl == CTL_RECV && link_d == $past(rx_byte)));

  // R9
  own_byte_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sid_valid && sid_ready) |=> (link_ctl == CTL_RECV && link_d == $past(sid_data)));

  // R7
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ctl == CTL_IDLE) |-> (!rx_byte_ready && !sid_ready));

  // R10
  prefix_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ctl == CTL_IDLE && rx_prefix && sid_valid) |=> !sid_ready);

endmodule

bind phy_link_rx_seq rxseq_chk #(
  .DATA_W     (DATA_W),
  .CTL_W      (CTL_W),
  .CTL_IDLE   (CTL_IDLE),
  .CTL_RECV   (CTL_RECV),
  .DATAON_PAT (DATAON_PAT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_prefix     (rx_prefix),
  .rx_byte_valid (rx_byte_valid),
  .rx_byte       (rx_byte),
  .rx_byte_ready (rx_byte_ready),
  .sid_valid     (sid_valid),
  .sid_data      (sid_data),
  .sid_ready     (sid_ready),
  .link_ctl      (link_ctl),
  .link_d        (link_d)
);

// File: tb/phy_link_rx_seq_tb.sv
`timescale 1ns/1ps
module phy_link_rx_seq_tb;

  localparam logic [1:0] C_IDLE = 2'b00;
  localparam logic [1:0] C_RECV = 2'b10;
  localparam logic [7:0] D_ON   = 8'hFF;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_prefix, rx_spd_valid, rx_byte_valid, rx_end;
  logic [1:0] rx_spd;
  logic [7:0] rx_byte;
  logic       rx_byte_ready;
  logic       sid_valid, sid_last, sid_ready;
  logic [7:0] sid_data;
  logic [1:0] link_ctl;
  logic [7:0] link_d;

  always #2.5 clk = ~clk;

  phy_link_rx_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_prefix(rx_prefix), .rx_spd_valid(rx_spd_valid), .rx_spd(rx_spd),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_byte_ready(rx_byte_ready),
    .rx_end(rx_end),
    .sid_valid(sid_valid), .sid_data(sid_data), .sid_last(sid_last), .sid_ready(sid_ready),
    .link_ctl(link_ctl), .link_d(link_d)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state: 0 idle, 1 cable data-on, 2 cable data, 3 own data-on, 4 own data, 5 tail
  int         m_st;
  bit         p_sv, p_end;
  logic [1:0] p_spd;
  logic [1:0] e_ctl;
  logic [7:0] e_d;
  string      e_tag;
  int         sid_left, sid_idx;
  logic [7:0] sid_base;

  function automatic logic [7:0] spd_exp(logic [1:0] s);
    case (s)
      2'd0: return 8'h00;
      2'd1: return 8'h40;
      default: return 8'h50;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs(string ph);
    chk(link_ctl == e_ctl, {ph, "/", e_tag}, "link_ctl", int'(link_ctl), int'(e_ctl));
    chk(link_d == e_d, {ph, "/", e_tag}, "link_d", int'(link_d), int'(e_d));
    chk(rx_byte_ready == (m_st == 2), {ph, "/R7"}, "rx_byte_ready", int'(rx_byte_ready), int'(m_st == 2));
    chk(sid_ready == (m_st == 4), {ph, "/R11"}, "sid_ready", int'(sid_ready), int'(m_st == 4));
  endtask

  task automatic sid_drive();
    if (sid_left > 0) begin
      sid_valid = 1'b1;
      sid_data  = sid_base + 8'(sid_idx);
      sid_last  = (sid_left == 1);
    end else begin
      sid_valid = 1'b0;
      sid_data  = 8'h00;
      sid_last  = 1'b0;
    end
  endtask

  task automatic set_out(logic [1:0] c, logic [7:0] d, string t);
    e_ctl = c; e_d = d; e_tag = t;
  endtask

  task automatic model_step();
    case (m_st)
      0: begin
        if (rx_prefix) begin
          p_sv = rx_spd_valid; p_spd = rx_spd; p_end = rx_end;
          set_out(C_RECV, D_ON, "R2"); m_st = 1;
        end else if (sid_valid) begin
          set_out(C_RECV, D_ON, "R9"); m_st = 3;
        end else set_out(C_IDLE, 8'h00, "R8");
      end
      1: begin
        if (p_end || rx_end) begin
          set_out(C_IDLE, 8'h00, "R4"); m_st = 0; p_sv = 0; p_end = 0;
        end else if (p_sv || rx_spd_valid) begin
          set_out(C_RECV, spd_exp(p_sv ? p_spd : rx_spd), "R3"); m_st = 2; p_sv = 0; p_end = 0;
        end else set_out(C_RECV, D_ON, "R2");
      end
      2: begin
        if (rx_byte_valid) begin
          set_out(C_RECV, rx_byte, "R5"); m_st = rx_end ? 5 : 2;
        end else if (rx_end) begin
          set_out(C_IDLE, 8'h00, "R6"); m_st = 0;
        end else set_out(C_RECV, D_ON, "R5");
      end
      3: begin
        set_out(C_RECV, 8'h00, "R9"); m_st = 4;
      end
      4: begin
        if (sid_valid) begin
          set_out(C_RECV, sid_data, "R9"); m_st = sid_last ? 5 : 4;
          sid_left--; sid_idx++;
        end else set_out(C_RECV, D_ON, "R9");
      end
      default: begin
        set_out(C_IDLE, 8'h00, "R6"); m_st = 0;
      end
    endcase
  endtask

  task automatic tick(string ph, bit pf, bit sv, logic [1:0] sp, bit bv, logic [7:0] b, bit en);
    @(negedge clk);
    check_outputs(ph);
    rx_prefix = pf; rx_spd_valid = sv; rx_spd = sp;
    rx_byte_valid = bv; rx_byte = b; rx_end = en;
    sid_drive();
    model_step();
  endtask

  task automatic quiet(string ph, int n);
    for (int i = 0; i < n; i++) tick(ph, 0, 0, 2'd0, 0, 8'h00, 0);
  endtask

  task automatic sid_start(int n);
    if (sid_left == 0) begin
      sid_left = n; sid_idx = 0; sid_base = 8'($urandom);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0005EED5));
    rst_n = 1'b0;
    rx_prefix = 0; rx_spd_valid = 0; rx_spd = 0; rx_byte_valid = 0; rx_byte = 0; rx_end = 0;
    sid_valid = 0; sid_data = 0; sid_last = 0;
    m_st = 0; p_sv = 0; p_end = 0; p_spd = 0; sid_left = 0; sid_idx = 0; sid_base = 0;
    set_out(C_IDLE, 8'h00, "R1");
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(link_ctl == C_IDLE, "R1", "link_ctl", int'(link_ctl), int'(C_IDLE));
    chk(link_d == 8'h00, "R1", "link_d", int'(link_d), 0);
    chk(!rx_byte_ready && !sid_ready, "R1", "ready", int'({rx_byte_ready, sid_ready}), 0);
    rst_n = 1'b1;
    quiet("R1", 2);

    // R4: null packet, end after a data-on gap
    tick("R4", 1, 0, 0, 0, 0, 0);
    quiet("R4", 2);
    tick("R4", 0, 1, 2'd2, 0, 0, 1);
    quiet("R4", 2);
    // R4: prefix and end in the same cycle
    tick("R4", 1, 0, 0, 0, 0, 1);
    quiet("R4", 2);

    // R3: every speed value including reserved, with gaps and end-with-byte
    for (int s = 0; s < 4; s++) begin
      tick("R3", 1, 0, 0, 0, 0, 0);
      quiet("R3", 1);
      tick("R3", 0, 1, 2'(s), 0, 0, 0);
      tick("R5", 0, 0, 0, 1, 8'hA0 + 8'(s), 0);
      quiet("R5", 1);
      tick("R5", 0, 0, 0, 1, 8'h3C, 0);
      tick("R6", 0, 0, 0, 1, 8'hC3, 1);
      quiet("R6", 2);
    end

    // R2: speed arriving with the prefix still gets a data-on cycle first
    tick("R2", 1, 1, 2'd1, 0, 0, 0);
    tick("R2", 0, 0, 0, 1, 8'h11, 0);
    tick("R6", 0, 0, 0, 0, 0, 1);
    quiet("R6", 2);

    // R7/R8: bytes before speed are dropped; events mid-transfer ignored
    tick("R8", 1, 0, 0, 1, 8'h55, 0);
    tick("R7", 0, 0, 0, 1, 8'h66, 0);
    tick("R8", 0, 1, 2'd2, 1, 8'h77, 0);
    tick("R8", 1, 1, 2'd0, 0, 0, 0);
    tick("R8", 0, 0, 0, 1, 8'h88, 0);
    tick("R6", 0, 0, 0, 0, 0, 1);
    tick("R8", 0, 1, 2'd1, 1, 8'h99, 1);
    quiet("R8", 2);

    // R10: self-ID offered in the same cycle as a cable prefix
    sid_start(4);
    tick("R10", 1, 0, 0, 0, 0, 0);
    tick("R10", 1, 1, 2'd2, 0, 0, 0);
    tick("R10", 0, 0, 0, 1, 8'h42, 0);
    tick("R10", 0, 0, 0, 0, 0, 1);
    quiet("R9", 10);

    // random traffic mixing both sources
    for (int i = 0; i < 4000; i++) begin
      if (sid_left == 0 && ($urandom % 40) == 0) sid_start(1 + int'($urandom % 6));
      tick("RND",
           ($urandom % 6) == 0,
           ($urandom % 4) == 0,
           2'($urandom),
           ($urandom % 2) == 0,
           8'($urandom),
           ($urandom % 9) == 0);
    end
    quiet("RND", 20);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule